// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing side of a three-channel interval timer. A 2-bit address and separate read and write strobes reach four byte-wide locations. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. A byte written to the control port is one of three things: a configuration word for one channel, a count-latch request for one channel, or a read-back command that can cover several channels at once.

Toward the three counting channels, the block delivers:
- an assembled 16-bit load value with a one-cycle strobe,
- the stored mode and BCD flag, with a strobe each time a channel is reconfigured.

From the channels it takes:
- a live 16-bit count,
- the output pin level,
- a null-count flag.

Reads of a data port return one of three things: a latched status byte, held count bytes, or bytes of the live count. Which bytes are returned follows the access format stored for that channel. The counting itself lives outside this block.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel has access format low-then-high (code 11), mode 0, binary counting, no latched count or status, and both byte pointers at the first byte. `ld_stb` and `cfg_stb` are low.
- R2: A control-port write whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are non-zero configures that channel. Bits 5:4 are the access format (01 high byte only, 10 low byte only, 11 low byte then high byte), bits 3:1 the mode and bit 0 the BCD flag. `cfg_stb` for that channel is high in the cycle after the write, with `mode_o`/`bcd_o` already updated. Both byte pointers return to the first byte and any latched count or status is discarded.
- R3: Data-port writes build the load value by format. High-only gives {byte,00}. Low-only gives {00,byte}. Low-then-high takes the first byte as bits 7:0 and the second as bits 15:8. `ld_stb` pulses in the cycle after the write that completes the value, and at most one channel pulses at a time.
- R4: A control-port write with bits 5:4 = 00 snapshots the named channel's live count. Later data-port reads return the snapshot's bytes in the channel's format, regardless of how the live count moves, until the last byte is read.
- R5: A count-latch request (from either command form) to a channel whose snapshot is still unread is ignored, and the held value is kept.
- R6: With nothing latched, data-port reads return bytes of the live count in the channel's format. In low-then-high format the read pointer alternates low, high.
- R7: A control write with bits 7:6 = 11 and bit 0 = 0 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches status. Status is {out level, null count, format[1:0], mode[2:0], BCD} from bit 7 down to bit 0.
- R8: When status and count are both latched for a channel, its first read returns the status byte and the following reads return the count bytes.
- R9: A read-back command with bit 0 = 1 latches nothing.
- R10: When `wr_en` and `rd_en` are high together, the write is performed, the read is ignored, and no read pointer or latch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Location select: 0-2 channel data, 3 control |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the cycle `rd_en` is high (control-port reads undefined) |
| cnt_in | input | 48 | Live counts, channel n in bits 16n+15:16n |
| out_in | input | 3 | Output pin level per channel |
| null_in | input | 3 | Null-count flag per channel |
| ld_val | output | 48 | Assembled load values, channel n in bits 16n+15:16n |
| ld_stb | output | 3 | Load value complete, one pulse per channel |
| cfg_stb | output | 3 | Channel reconfigured, one pulse |
| mode_o | output | 9 | Stored mode, channel n in bits 3n+2:3n |
| bcd_o | output | 3 | Stored BCD flag per channel |

## Verification
Two functions can meet in a single control write: a read-back command that asks for both status and count on a channel whose earlier count latch is only half read. In that cycle the status is captured while the count request is refused. The bench provokes this by latching channel 2, reading only its low byte, moving the live count, then issuing a combined read-back. It passes only if the next read yields the status byte and the one after it yields the high byte of the original snapshot. Simultaneous read and write strobes are judged the same way: a completed load value must appear, and the following read must still return the low byte.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int NCH  = 3;
  localparam int CW   = 16;
  localparam int BW   = 8;
  localparam int MW   = 3;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'b00,
    FMT_HI    = 2'b01,
    FMT_LO    = 2'b10,
    FMT_PAIR  = 2'b11
  } acc_fmt_e;

  // byte of a count picked by access format and read pointer
  function automatic logic [7:0] sel_byte(acc_fmt_e f, logic second, logic [15:0] v);
    logic take_hi;
    take_hi = (f == FMT_HI) || ((f == FMT_PAIR) && second);
    return take_hi ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [7:0] pack_status(logic o, logic nc, acc_fmt_e f,
                                             logic [2:0] m, logic b);
    return {o, nc, f, m, b};
  endfunction
endpackage

// File: rtl/tmr_host_decode.sv
module tmr_host_decode
  import tmr_host_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [7:0]   wdata,
  output logic [N-1:0] cfg_we,
  output logic [N-1:0] cnt_lat,
  output logic [N-1:0] sts_lat,
  output logic [N-1:0] dat_we,
  output logic [N-1:0] dat_re
);
  logic ctl_wr, rd_ok, is_rb, rb_valid;

  assign ctl_wr   = wr_en && (addr == 2'd3);
  assign rd_ok    = rd_en && !wr_en;
  assign is_rb    = (wdata[7:6] == 2'b11);
  assign rb_valid = ctl_wr && is_rb && !wdata[0];

  for (genvar c = 0; c < N; c++) begin : g_dec
    logic hit;
    assign hit        = !is_rb && (wdata[7:6] == 2'(c));
    assign cfg_we[c]  = ctl_wr && hit && (wdata[5:4] != 2'b00);
    assign cnt_lat[c] = (ctl_wr && hit && (wdata[5:4] == 2'b00)) ||
                        (rb_valid && wdata[c+1] && !wdata[5]);
    assign sts_lat[c] = rb_valid && wdata[c+1] && !wdata[4];
    assign dat_we[c]  = wr_en && (addr == 2'(c));
    assign dat_re[c]  = rd_ok && (addr == 2'(c));
  end

  AST_RB_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && is_rb && wdata[0]) |-> (cnt_lat == '0 && sts_lat == '0)); // R9
  AST_READ_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (dat_re == '0)); // R10
endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
  import tmr_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cnt_lat,
  input  logic        sts_lat,
  input  logic        dat_we,
  input  logic        dat_re,
  input  logic [7:0]  wdata,
  input  logic [15:0] cnt_in,
  input  logic        out_in,
  input  logic        null_in,
  output logic [15:0] ld_val,
  output logic        ld_stb,
  output logic        cfg_stb,
  output logic [2:0]  mode_o,
  output logic        bcd_o,
  output logic [7:0]  rd_byte
);
  acc_fmt_e    fmt_q;
  logic [2:0]  mode_q;
  logic        bcd_q;
  logic        wr_ptr_q, rd_ptr_q;
  logic [7:0]  lo_q;
  logic [15:0] cnt_hold_q, ld_val_q;
  logic        cnt_vld_q, sts_vld_q;
  logic [7:0]  sts_q;
  logic        ld_stb_q, cfg_stb_q;

  // named events for the checks below
  logic cnt_take, sts_take, cnt_release, pair_done;
  assign cnt_take    = cnt_lat && !cnt_vld_q;
  assign sts_take    = sts_lat && !sts_vld_q;
  assign cnt_release = dat_re && !sts_vld_q && cnt_vld_q &&
                       ((fmt_q != FMT_PAIR) || rd_ptr_q);
  assign pair_done   = dat_we && (fmt_q == FMT_PAIR) && wr_ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q      <= FMT_PAIR;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_ptr_q   <= 1'b0;
      rd_ptr_q   <= 1'b0;
      lo_q       <= '0;
      cnt_hold_q <= '0;
      cnt_vld_q  <= 1'b0;
      sts_q      <= '0;
      sts_vld_q  <= 1'b0;
      ld_val_q   <= '0;
      ld_stb_q   <= 1'b0;
      cfg_stb_q  <= 1'b0;
    end else begin
      ld_stb_q  <= 1'b0;
      cfg_stb_q <= 1'b0;
      if (cfg_we) begin
        fmt_q     <= acc_fmt_e'(wdata[5:4]);
        mode_q    <= wdata[3:1];
        bcd_q     <= wdata[0];
        wr_ptr_q  <= 1'b0;
        rd_ptr_q  <= 1'b0;
        cnt_vld_q <= 1'b0;
        sts_vld_q <= 1'b0;
        cfg_stb_q <= 1'b1;
      end else begin
        if (cnt_take) begin
          cnt_hold_q <= cnt_in;
          cnt_vld_q  <= 1'b1;
        end
        if (sts_take) begin
          sts_q     <= pack_status(out_in, null_in, fmt_q, mode_q, bcd_q);
          sts_vld_q <= 1'b1;
        end
        if (dat_we) begin
          unique case (fmt_q)
            FMT_HI: begin
              ld_val_q <= {wdata, 8'h00};
              ld_stb_q <= 1'b1;
            end
            FMT_LO: begin
              ld_val_q <= {8'h00, wdata};
              ld_stb_q <= 1'b1;
            end
            FMT_PAIR: begin
              if (wr_ptr_q) begin
                ld_val_q <= {wdata, lo_q};
                ld_stb_q <= 1'b1;
              end else begin
                lo_q <= wdata;
              end
              wr_ptr_q <= ~wr_ptr_q;
            end
            default: ;
          endcase
        end
        if (dat_re) begin
          if (sts_vld_q) begin
            sts_vld_q <= 1'b0;
          end else begin
            if (fmt_q == FMT_PAIR) rd_ptr_q <= ~rd_ptr_q;
            if (cnt_release) cnt_vld_q <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_byte = sts_vld_q ? sts_q
                 : sel_byte(fmt_q, rd_ptr_q, cnt_vld_q ? cnt_hold_q : cnt_in);
  assign ld_val  = ld_val_q;
  assign ld_stb  = ld_stb_q;
  assign cfg_stb = cfg_stb_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_vld_q && !cfg_we && !cnt_release) |=> (cnt_vld_q && $stable(cnt_hold_q))); // R5
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && sts_vld_q) |=> (!sts_vld_q && $stable(cnt_vld_q) && $stable(rd_ptr_q))); // R8
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_stb && !cnt_vld_q && !sts_vld_q && !wr_ptr_q && !rd_ptr_q)); // R2
  AST_PAIR_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> (ld_stb && ld_val[7:0] == $past(lo_q) && ld_val[15:8] == $past(wdata))); // R3
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic [NCH*CW-1:0] cnt_in,
  input  logic [NCH-1:0]    out_in,
  input  logic [NCH-1:0]    null_in,
  output logic [NCH*CW-1:0] ld_val,
  output logic [NCH-1:0]    ld_stb,
  output logic [NCH-1:0]    cfg_stb,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    bcd_o
);
  logic [NCH-1:0] cfg_we, cnt_lat, sts_lat, dat_we, dat_re;
  logic [BW-1:0]  rd_b [NCH];

  tmr_host_decode #(.N(NCH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .cfg_we  (cfg_we),
    .cnt_lat (cnt_lat),
    .sts_lat (sts_lat),
    .dat_we  (dat_we),
    .dat_re  (dat_re)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_host_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we[c]),
      .cnt_lat (cnt_lat[c]),
      .sts_lat (sts_lat[c]),
      .dat_we  (dat_we[c]),
      .dat_re  (dat_re[c]),
      .wdata   (wdata),
      .cnt_in  (cnt_in[c*CW +: CW]),
      .out_in  (out_in[c]),
      .null_in (null_in[c]),
      .ld_val  (ld_val[c*CW +: CW]),
      .ld_stb  (ld_stb[c]),
      .cfg_stb (cfg_stb[c]),
      .mode_o  (mode_o[c*MW +: MW]),
      .bcd_o   (bcd_o[c]),
      .rd_byte (rd_b[c])
    );
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++)
      if (dat_re[c]) rdata = rd_b[c];
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb)); // R3
  AST_ONE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_stb)); // R2
endmodule

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [47:0] cnt_in = '0;
  logic [2:0]  out_in = '0, null_in = '0;
  logic [47:0] ld_val;
  logic [2:0]  ld_stb, cfg_stb, bcd_o;
  logic [8:0]  mode_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_host_if u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_in(cnt_in), .out_in(out_in), .null_in(null_in),
    .ld_val(ld_val), .ld_stb(ld_stb), .cfg_stb(cfg_stb), .mode_o(mode_o), .bcd_o(bcd_o));

  function automatic logic [7:0] want_byte(logic [1:0] f, bit second, logic [15:0] v);
    if (f == 2'b10) return v[7:0];
    if (f == 2'b01) return v[15:8];
    return second ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [15:0] want_load(logic [1:0] f, logic [7:0] a, logic [7:0] b);
    case (f)
      2'b01:   return {a, 8'h00};
      2'b10:   return {8'h00, a};
      default: return {b, a};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 ld_stb", {13'd0, ld_stb}, 16'd0);
    chk("R1 cfg_stb", {13'd0, cfg_stb}, 16'd0);
    chk("R1 mode", {7'd0, mode_o}, 16'd0);
    chk("R1 bcd", {13'd0, bcd_o}, 16'd0);
    do_wr(2'd0, 8'h3c);
    chk("R1 pair first no stb", {15'd0, ld_stb[0]}, 16'd0);
    do_wr(2'd0, 8'hc3);
    chk("R1 default pair load", ld_val[15:0], 16'hc33c);

    // R2/R3: channel 1 high-only, mode 3, BCD
    do_wr(2'd3, 8'b01_01_011_1);
    chk("R2 cfg_stb", {13'd0, cfg_stb}, 16'b010);
    chk("R2 mode", {13'd0, mode_o[5:3]}, 16'd3);
    chk("R2 bcd", {15'd0, bcd_o[1]}, 16'd1);
    do_wr(2'd1, 8'ha5);
    chk("R3 high only", ld_val[31:16], 16'ha500);

    // randomized sweep: R2, R3, R4, R5, R6
    for (int it = 0; it < 60; it++) begin
      int c = $urandom % 3;
      logic [1:0] f = 2'($urandom % 3 + 1);
      logic [2:0] m = 3'($urandom % 6);
      logic bc = 1'($urandom);
      logic [7:0] x0 = 8'($urandom), x1 = 8'($urandom);
      logic [15:0] v = 16'($urandom), w;
      do_wr(2'd3, {2'(c), f, m, bc});
      chk("R2 cfg sweep", {13'd0, cfg_stb}, 16'(1 << c));
      chk("R2 mode sweep", {13'd0, mode_o[c*3 +: 3]}, {13'd0, m});
      do_wr(2'(c), x0);
      if (f == 2'b11) begin
        chk("R3 pair half", {15'd0, ld_stb[c]}, 16'd0);
        do_wr(2'(c), x1);
      end
      chk("R3 load stb", {13'd0, ld_stb}, 16'(1 << c));
      chk("R3 load val", ld_val[c*16 +: 16], want_load(f, x0, x1));
      // R4: latch then move the live count
      cnt_in[c*16 +: 16] = v;
      do_wr(2'd3, {2'(c), 6'b0});
      cnt_in[c*16 +: 16] = 16'($urandom);
      do_rd(2'(c), b);
      chk("R4 latched first", {8'd0, b}, {8'd0, want_byte(f, 1'b0, v)});
      if (f == 2'b11) begin
        // R5: second latch while half read is ignored
        cnt_in[c*16 +: 16] = ~v;
        do_wr(2'd3, {2'(c), 6'b0});
        do_rd(2'(c), b);
        chk("R5 latch ignored", {8'd0, b}, {8'd0, v[15:8]});
      end
      // R6: live reads
      w = 16'($urandom);
      cnt_in[c*16 +: 16] = w;
      do_rd(2'(c), b);
      chk("R6 live first", {8'd0, b}, {8'd0, want_byte(f, 1'b0, w)});
      if (f == 2'b11) begin
        do_rd(2'(c), b);
        chk("R6 live second", {8'd0, b}, {8'd0, w[15:8]});
      end
    end

    // R7/R8: read-back of status and count on channel 2
    do_wr(2'd3, 8'b10_11_010_0);
    out_in = 3'b100; null_in = 3'b000;
    cnt_in[47:32] = 16'h1234;
    do_wr(2'd3, 8'b11_0_0_1_0_0_0);
    out_in = 3'b000; null_in = 3'b111; cnt_in[47:32] = 16'hffff;
    do_rd(2'd2, b); chk("R7 R8 status first", {8'd0, b}, 16'h00b4);
    do_rd(2'd2, b); chk("R8 count low", {8'd0, b}, 16'h0034);
    do_rd(2'd2, b); chk("R8 count high", {8'd0, b}, 16'h0012);

    // R7: status only on channels 0 and 1
    do_wr(2'd3, 8'b00_10_001_1);
    do_wr(2'd3, 8'b01_11_101_0);
    out_in = 3'b001; null_in = 3'b010;
    do_wr(2'd3, 8'b11_1_0_0_1_1_0);
    out_in = 3'b110; null_in = 3'b101;
    cnt_in[15:0] = 16'h00aa; cnt_in[31:16] = 16'h5500;
    do_rd(2'd0, b); chk("R7 status ch0", {8'd0, b}, 16'h00a3);
    do_rd(2'd1, b); chk("R7 status ch1", {8'd0, b}, 16'h007a);
    do_rd(2'd0, b); chk("R7 no count ch0", {8'd0, b}, 16'h00aa);

    // combined: status latched while count latch is still held (R5, R8)
    cnt_in[47:32] = 16'habcd;
    do_wr(2'd3, 8'b10_00_0000);
    do_rd(2'd2, b); chk("R4 held low", {8'd0, b}, 16'h00cd);
    cnt_in[47:32] = 16'h0f0f; out_in = 3'b000; null_in = 3'b100;
    do_wr(2'd3, 8'b11_0_0_1_0_0_0);
    do_rd(2'd2, b); chk("R8 status before held", {8'd0, b}, 16'h0074);
    do_rd(2'd2, b); chk("R5 held high kept", {8'd0, b}, 16'h00ab);

    // R9: reserved bit set latches nothing
    cnt_in[47:32] = 16'h2468;
    do_wr(2'd3, 8'b11_0_0_1_0_0_1);
    cnt_in[47:32] = 16'h1357;
    do_rd(2'd2, b); chk("R9 ignored live low", {8'd0, b}, 16'h0057);
    do_rd(2'd2, b); chk("R9 ignored live high", {8'd0, b}, 16'h0013);

    // R10: simultaneous strobes, write wins
    do_wr(2'd3, 8'b00_11_000_0);
    cnt_in[15:0] = 16'h9abc;
    @(negedge clk); addr = 2'd0; wdata = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    do_wr(2'd0, 8'h88);
    chk("R10 write done", ld_val[15:0], 16'h8877);
    do_rd(2'd0, b); chk("R10 read ptr unmoved", {8'd0, b}, 16'h00bc);

    finish_run();
  end
endmodule